// File: doc/BRIEF.md
# Packed-Nibble Tile Pixel Fetcher

This block turns one pixel request into one graphics-ROM read and one 4-bit pixel. A request carries a tile code, a pixel column and row inside the tile, a mirror flag and a size select. The size select chooses between an 8x8 character and a 16x16 sprite. Pixels are stored four bits each, two to a byte, with all four bitplanes of a pixel held in the same nibble. The block forms the byte address and the nibble select, issues the read, and then picks the nibble out of the returned byte.

A 16x16 sprite is assembled from four 8x8 quadrants placed at fixed byte offsets inside a 128-byte sprite. An alternate column mode exists for character data that was stored with its columns rotated. Requests use a valid/ready handshake and may arrive back to back. The ROM port has a fixed latency of one cycle. The pixel appears one cycle after its byte returns. Character and sprite data sit in separate ROM regions, and the region is signalled with each read.

Top module: `tile_pix_fetch`

## Requirements
- R1: While reset is held, reqReady, romRd and pixValid are low. reqReady rises on the first clock edge after reset is released and then stays high.
- R2: For a character (reqSprite=0) with effective column x and row y in 0..7 and stored column n, the read has romSprite=0 and romAddr = code*32 + y*4 + n/2.
- R3: A stored column n that is even selects romData[7:4], and an odd n selects romData[3:0]. For sprites, n is the effective column modulo 8.
- R4: For a sprite (reqSprite=1) with effective column x and row y in 0..15, the read has romSprite=1 and romAddr = code*128 + (x>=8)*32 + (y>=8)*64 + (y mod 8)*4 + (x mod 8)/2.
- R5: With reqFlip=1, the effective column is max-col and the effective row is max-row, where max is 7 for characters and 15 for sprites. With reqFlip=0, both pass unchanged.
- R6: With altColMode=1, a character's stored column is n = (x+6) mod 8, so columns 0..7 read stored positions 6,7,0,1,2,3,4,5. With altColMode=0, n = x. Sprites ignore altColMode.
- R7: romRd is high for exactly the one cycle after each edge that accepts a request (reqValid and reqReady high). romData is sampled one cycle after that romRd cycle.
- R8: pixValid is high exactly two cycles after each romRd cycle, carrying that request's pixel. Requests accepted on consecutive edges yield pixels on consecutive cycles, in order. pixData does not change in cycles when pixValid is low.
- R9: For characters, bit 3 of reqCol and of reqRow is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block accepts a request this cycle |
| reqSprite | input | 1 | 1 = 16x16 sprite, 0 = 8x8 character |
| reqCode | input | 9 | Tile or sprite number |
| reqCol | input | 4 | Pixel column inside the tile |
| reqRow | input | 4 | Pixel row inside the tile |
| reqFlip | input | 1 | Mirror column and row |
| altColMode | input | 1 | Rotated character column order |
| romRd | output | 1 | ROM read strobe |
| romSprite | output | 1 | Read targets the sprite region |
| romAddr | output | 16 | ROM byte address |
| romData | input | 8 | ROM byte, valid the cycle after romRd |
| pixValid | output | 1 | Pixel output valid |
| pixData | output | 4 | Pixel value |

## Verification
Two things can coincide in one clock edge: a new request being launched to the ROM, and the byte of an earlier request being captured into the pixel register. A burst of requests on consecutive cycles forces this, and the burst mixes characters, sprites, flip and rotated-column mode so that each launch overwrites the pending nibble select while an older one is still in use. The reference model holds the expected addresses and pixels in queues, each tagged with its due cycle. It judges romRd, romAddr, romSprite, pixValid and pixData on every cycle, so a pixel that picks up a neighbour's nibble or lands one cycle early or late is caught.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int PIX_W  = 4;
  localparam int BYTE_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // request accepted this edge: register address/nibble
    logic capture;  // ROM byte present this cycle: register pixel
  } strobe_t;
endpackage

// File: rtl/tpf_ctrl.sv
module tpf_ctrl (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  output logic             reqReady,
  output logic             romRd,
  output logic             pixValid,
  output tpf_pkg::strobe_t stb
);
  logic readyQ, rdQ, dataQ, pixQ;
  logic accept;

  assign accept = reqValid && readyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      readyQ <= 1'b0;
      rdQ    <= 1'b0;
      dataQ  <= 1'b0;
      pixQ   <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      rdQ    <= accept;
      dataQ  <= rdQ;
      pixQ   <= dataQ;
    end
  end

  assign reqReady    = readyQ;
  assign romRd       = rdQ;
  assign pixValid    = pixQ;
  assign stb.launch  = accept;
  assign stb.capture = dataQ;

  // R1: once ready, stays ready
  p_ready_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    $past(reqReady) |-> reqReady);
  // R1: no read unless the block was ready the edge before
  p_no_rd_before_ready_r1: assert property (@(posedge clk) disable iff (rst)
    romRd |-> $past(reqReady));
  // R8: a pixel is always two cycles behind a read
  p_pix_after_rd_r8: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> $past(romRd, 2));
endmodule

// File: rtl/tpf_datapath.sv
module tpf_datapath #(
  parameter int CODE_W = 9,
  parameter int POS_W  = 4,
  parameter int ADDR_W = CODE_W + 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  tpf_pkg::strobe_t          stb,
  input  logic                      reqSprite,
  input  logic [CODE_W-1:0]         reqCode,
  input  logic [POS_W-1:0]          reqCol,
  input  logic [POS_W-1:0]          reqRow,
  input  logic                      reqFlip,
  input  logic                      altColMode,
  input  logic                      romRd,
  output logic                      romSprite,
  output logic [ADDR_W-1:0]         romAddr,
  input  logic [tpf_pkg::BYTE_W-1:0] romData,
  output logic [tpf_pkg::PIX_W-1:0]  pixData
);
  import tpf_pkg::*;

  localparam int CHAR_ADDR_W = CODE_W + 5;  // 32 bytes per character
  localparam int SPR_ADDR_W  = CODE_W + 7;  // 128 bytes per sprite
  localparam logic [2:0] ROT = 3'd6;

  logic [POS_W-1:0]       colEff, rowEff;
  logic [2:0]             charCol;
  logic [CHAR_ADDR_W-1:0] charAddr;
  logic [SPR_ADDR_W-1:0]  sprAddr;
  logic [ADDR_W-1:0]      nextAddr;
  logic                   nextNib;
  logic                   nibQ, nibData;

  // mirror is a bitwise invert: 7-x on 3 bits, 15-x on 4 bits
  assign colEff  = reqFlip ? ~reqCol : reqCol;
  assign rowEff  = reqFlip ? ~reqRow : reqRow;
  assign charCol = altColMode ? (colEff[2:0] + ROT) : colEff[2:0];

  // character: code | row | stored column pair
  assign charAddr = {reqCode, rowEff[2:0], charCol[2:1]};
  // sprite: code | lower quadrant | right quadrant | row | column pair
  assign sprAddr  = {reqCode, rowEff[3], colEff[3], rowEff[2:0], colEff[2:1]};

  always_comb begin
    if (reqSprite) begin
      nextAddr = ADDR_W'(sprAddr);
      nextNib  = colEff[0];
    end else begin
      nextAddr = ADDR_W'(charAddr);
      nextNib  = charCol[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      romAddr   <= '0;
      romSprite <= 1'b0;
      nibQ      <= 1'b0;
      nibData   <= 1'b0;
      pixData   <= '0;
    end else begin
      if (stb.launch) begin
        romAddr   <= nextAddr;
        romSprite <= reqSprite;
        nibQ      <= nextNib;
      end
      nibData <= nibQ;
      if (stb.capture)
        pixData <= nibData ? romData[PIX_W-1:0] : romData[BYTE_W-1:PIX_W];
    end
  end

  // R2: character reads stay inside the character region
  p_char_range_r2: assert property (@(posedge clk) disable iff (rst)
    (romRd && !romSprite) |-> (romAddr < ADDR_W'(1 << CHAR_ADDR_W)));
  // R8: the pixel register only moves on a capture strobe
  p_pix_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !stb.capture |=> $stable(pixData));
endmodule

// File: rtl/tile_pix_fetch.sv
module tile_pix_fetch #(
  parameter int CODE_W = 9,
  parameter int POS_W  = 4,
  parameter int ADDR_W = CODE_W + 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqSprite,
  input  logic [CODE_W-1:0] reqCode,
  input  logic [POS_W-1:0]  reqCol,
  input  logic [POS_W-1:0]  reqRow,
  input  logic              reqFlip,
  input  logic              altColMode,
  output logic              romRd,
  output logic              romSprite,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [7:0]        romData,
  output logic              pixValid,
  output logic [3:0]        pixData
);
  tpf_pkg::strobe_t stb;

  tpf_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .romRd    (romRd),
    .pixValid (pixValid),
    .stb      (stb)
  );

  tpf_datapath #(.CODE_W(CODE_W), .POS_W(POS_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .reqSprite  (reqSprite),
    .reqCode    (reqCode),
    .reqCol     (reqCol),
    .reqRow     (reqRow),
    .reqFlip    (reqFlip),
    .altColMode (altColMode),
    .romRd      (romRd),
    .romSprite  (romSprite),
    .romAddr    (romAddr),
    .romData    (romData),
    .pixData    (pixData)
  );
endmodule

// File: tb/sim_tile_pix_fetch.sv
module sim_tile_pix_fetch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqSprite = 1'b0, reqFlip = 1'b0, altColMode = 1'b0;
  logic [8:0] reqCode = '0;
  logic [3:0] reqCol = '0, reqRow = '0;
  logic reqReady, romRd, romSprite, pixValid;
  logic [15:0] romAddr;
  logic [7:0]  romData = '0;
  logic [3:0]  pixData;

  int total = 0, bad = 0;
  int idx = 0, sinceRel = -1;
  bit done = 0;
  int addrDue[$], addrExp[$], sprExp[$], pixDue[$], pixExp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_pix_fetch u0 (.*);

  function automatic logic [7:0] romByte(input logic spr, input logic [15:0] a);
    int v = int'(a) * 7 + (int'(a) >> 5) + (spr ? 113 : 29);
    return v[7:0];
  endfunction

  // ROM model with one-cycle latency
  always @(posedge clk) romData <= romRd ? romByte(romSprite, romAddr) : 8'h00;

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, idx);
    end
  endfunction

  // reference model: address and pixel from the requirement formulas
  function automatic void model(input bit spr, input int code, input int col, input int row,
                                input bit flip, input bit alt, output int addr, output bit hi);
    int x, y, n, bitOff, base;
    if (spr) begin // R4, R5
      x = flip ? 15 - col : col;
      y = flip ? 15 - row : row;
      bitOff = (x % 8) * 4 + (y % 8) * 32 + (x / 8) * 256 + (y / 8) * 512;
      base = code * 128;
    end else begin // R2, R5, R6, R9
      x = col % 8; y = row % 8;
      if (flip) begin x = 7 - x; y = 7 - y; end
      n = alt ? (x + 6) % 8 : x;
      bitOff = n * 4 + y * 32;
      base = code * 32;
    end
    addr = base + bitOff / 8;
    hi = ((bitOff % 8) == 0); // R3
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      chk(!reqReady && !romRd && !pixValid, "R1", {reqReady, romRd, pixValid}, 0);
    end else begin
      sinceRel++;
      chk(reqReady == (sinceRel >= 1), "R1", reqReady, sinceRel >= 1);
      if (addrDue.size() > 0 && addrDue[0] == idx) begin
        chk(romRd == 1'b1, "R7", romRd, 1);
        chk(int'(romAddr) == addrExp[0], sprExp[0] ? "R4" : "R2", romAddr, addrExp[0]);
        chk(int'(romSprite) == sprExp[0], sprExp[0] ? "R4" : "R2", romSprite, sprExp[0]);
        void'(addrDue.pop_front()); void'(addrExp.pop_front()); void'(sprExp.pop_front());
      end else
        chk(romRd == 1'b0, "R7", romRd, 0);
      if (pixDue.size() > 0 && pixDue[0] == idx) begin
        chk(pixValid == 1'b1, "R8", pixValid, 1);
        chk(int'(pixData) == pixExp[0], "R3", pixData, pixExp[0]);
        void'(pixDue.pop_front()); void'(pixExp.pop_front());
      end else
        chk(pixValid == 1'b0, "R8", pixValid, 0);
      if (reqValid && reqReady) begin
        int a; bit h; logic [7:0] b;
        model(reqSprite, reqCode, reqCol, reqRow, reqFlip, altColMode, a, h);
        b = romByte(reqSprite, 16'(a));
        addrDue.push_back(idx + 1); addrExp.push_back(a); sprExp.push_back(int'(reqSprite));
        pixDue.push_back(idx + 3); pixExp.push_back(h ? int'(b[7:4]) : int'(b[3:0]));
      end
    end
    idx++;
  end

  task automatic send(input bit spr, input int code, input int col, input int row,
                      input bit flip, input bit alt);
    reqValid = 1; reqSprite = spr; reqCode = 9'(code);
    reqCol = 4'(col); reqRow = 4'(row); reqFlip = flip; altColMode = alt;
    forever begin @(negedge clk); if (reqReady) break; end
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    idle(3);
    // R2 R3: plain characters, every column of one row
    for (int c = 0; c < 8; c++) send(0, 37, c, 3, 0, 0);
    idle(2);
    // R5: flipped characters
    for (int c = 0; c < 8; c++) send(0, 511, c, c, 1, 0);
    // R6: rotated column order, with and without flip
    for (int c = 0; c < 8; c++) send(0, 100, c, 5, 0, 1);
    for (int c = 0; c < 8; c++) send(0, 100, c, 5, 1, 1);
    idle(1);
    // R9: upper position bit ignored for characters
    send(0, 200, 12, 9, 0, 0);
    send(0, 200, 15, 14, 1, 1);
    // R4: every quadrant of a sprite, R6 ignored for sprites
    for (int r = 0; r < 16; r += 5)
      for (int c = 0; c < 16; c++) send(1, 300, c, r, 0, c[0]);
    // R5: flipped sprites
    for (int c = 0; c < 16; c++) send(1, 511, c, 15 - c, 1, 0);
    idle(3);
    // R7 R8: mixed burst with gaps
    for (int i = 0; i < 300; i++) begin
      send($urandom_range(0, 1), $urandom_range(0, 511), $urandom_range(0, 15),
           $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    // R8: every expected pixel was delivered
    chk(pixDue.size() == 0 && addrDue.size() == 0, "R8", pixDue.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule